// File: doc/BRIEF.md
# Double-Buffered Weight-Stationary Systolic Matrix Engine

This block is a square grid of multiply-accumulate cells. It multiplies a stream of input vectors by a weight matrix that stays inside the grid. Each vector, called a sample, enters from the left edge with one element per row. The element for row r is presented r cycles after the element for row 0. Each element moves one cell to the right per clock. Partial sums start at zero above the top row and move one cell down per clock. Each column leaves the bottom row as its own result stream, one output feature per column.

Every cell has two weight registers: an active weight that feeds the multiplier and a shadow weight that holds the next layer. Weight rows are shifted into the shadow registers from the top while the active weights keep computing. A switch pulse then sweeps diagonally through the grid and swaps the shadow weights in, one wavefront behind the samples it applies to. Consecutive layers can therefore stream back to back without stopping to reload weights. A compute enable travels the same diagonal path, so each cell works only in the cycles when valid data reaches it.

Top module: `sys_array_db`

## Requirements
- R1: All data is signed Q8.8. For a sample k with elements x[k][r], output column c equals the sum over rows r of the rounded product x[k][r]·W[r][c]. W[r][c] is the active weight in the cell at row r, column c. The sum is accumulated in row order, starting from 0 at row 0.
- R2: Each product is rounded and saturated in three steps. The full product has 128 added. It is then shifted arithmetically right by 8. The result is saturated to the range [-32768, 32767]. Each addition into the partial sum saturates to the same range.
- R3: Element r of sample k is applied on x_i[r] in cycle k+r. The result for sample k appears on y_o[c] at the clock edge that closes cycle k+N-1+c. It holds that value until the next update.
- R4: Setting en_i high in cycle k enables the cell at (r,c) in cycle k+r+c. A cell that is not enabled holds its forwarded input and its partial sum. Values on x_i in cycles when the cell is not enabled have no effect, and y_o holds its value.
- R5: On each edge where accept_i is high, the row-0 shadow weights take w_row_i[c], and every other row takes the shadow weights of the row above it. Loading a full matrix therefore takes N accepts, with the bottom row presented first. When accept_i is low, the shadow weights hold.
- R6: With switch_i high in cycle K, each cell copies its shadow weight into its active weight in cycle K+r+c. The sample that entered in cycle K and all later samples use the new weights. Earlier samples use the old weights.
- R7: Pulling rst_ni low clears all of the following at once, without waiting for a clock: active weights, shadow weights, forwarded inputs, partial sums and the travelling enable and switch bits. y_o reads zero as a result.
- R8: Accepts that occur while samples are streaming do not change the results of samples that entered before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Compute enable for the sample that enters row 0 in this cycle |
| switch_i | input | 1 | Start of the shadow-to-active swap wavefront |
| accept_i | input | 1 | Shift the shadow weights down one row and load w_row_i into row 0 |
| x_i | input | N×DW | Left-edge inputs, one signed Q8.8 element per row, skewed by row |
| w_row_i | input | N×DW | One row of weights, one element per column |
| y_o | output | N×DW | Bottom-row partial sums, one per column |

## Verification
The assertions assume that accept_i stays low while a switch wavefront is still travelling, which lasts 2N-2 cycles after switch_i. Otherwise a late cell would copy a shadow weight that has already been shifted. They also assume that the row inputs are skewed as R3 describes. The stimulus follows both rules. After each preload switch it waits 2N cycles. Inside a stream it issues every accept before the cycle that carries switch_i, and no accept follows until the next case. Cycles outside a row's valid window carry random values instead of zeros, so the enable wavefront is what keeps those values out of the results.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // control bits that travel diagonally through the grid
  typedef struct packed {
    logic en;
    logic sw;
  } sa_ctl_t;
endpackage

// File: rtl/sa_mac.sv
module sa_mac #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [DW-1:0] psum_i,
  output logic signed [DW-1:0] sum_o
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW:0] HI  = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0] LO  = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [PW:0] RND = (PW+1)'(2 ** (FRAC-1));

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   prod_rnd;
  logic signed [PW:0]   prod_shr;
  logic signed [DW-1:0] prod_sat;
  logic signed [DW:0]   sum_w;

  always_comb begin
    prod     = PW'(x_i) * PW'(w_i);
    prod_rnd = {prod[PW-1], prod} + RND;
    prod_shr = prod_rnd >>> FRAC;
    if (prod_shr > HI)      prod_sat = HI[DW-1:0];
    else if (prod_shr < LO) prod_sat = LO[DW-1:0];
    else                    prod_sat = prod_shr[DW-1:0];
    sum_w = {psum_i[DW-1], psum_i} + {prod_sat[DW-1], prod_sat};
    // overflow when the two top bits disagree
    if (sum_w[DW] != sum_w[DW-1]) sum_o = sum_w[DW] ? LO[DW-1:0] : HI[DW-1:0];
    else                          sum_o = sum_w[DW-1:0];
  end
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  sa_ctl_t              ctl_i,
  input  logic                 acc_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] psum_i,
  input  logic signed [DW-1:0] sh_i,
  output sa_ctl_t              ctl_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] psum_o,
  output logic signed [DW-1:0] sh_o
);
  sa_ctl_t              ctl_q;
  logic signed [DW-1:0] x_q, psum_q, act_q, sh_q;
  logic signed [DW-1:0] w_use, mac_sum;

  // the swap cycle already computes with the incoming weight
  assign w_use = ctl_i.sw ? sh_q : act_q;

  sa_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
    .x_i    (x_i),
    .w_i    (w_use),
    .psum_i (psum_i),
    .sum_o  (mac_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      x_q    <= '0;
      psum_q <= '0;
      act_q  <= '0;
      sh_q   <= '0;
    end else begin
      ctl_q <= ctl_i;
      if (ctl_i.sw) act_q <= sh_q;
      if (acc_i)    sh_q  <= sh_i;
      if (ctl_i.en) begin
        x_q    <= x_i;
        psum_q <= mac_sum;
      end
    end
  end

  assign ctl_o  = ctl_q;
  assign x_o    = x_q;
  assign psum_o = psum_q;
  assign sh_o   = sh_q;

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.en |=> $stable(psum_q) && $stable(x_q));
  p_zero_x_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.en && x_i == '0) |=> psum_q == $past(psum_i));
  p_act_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.sw |=> $stable(act_q));
  p_sh_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(sh_q));
endmodule

// File: rtl/sys_array_db.sv
module sys_array_db
  import sa_pkg::*;
#(
  parameter int N    = 2,
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 switch_i,
  input  logic                 accept_i,
  input  logic [N-1:0][DW-1:0] x_i,
  input  logic [N-1:0][DW-1:0] w_row_i,
  output logic [N-1:0][DW-1:0] y_o
);
  sa_ctl_t              ctl_w [N][N];
  logic signed [DW-1:0] x_w   [N][N];
  logic signed [DW-1:0] ps_w  [N][N];
  logic signed [DW-1:0] sh_w  [N][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sa_ctl_t              ctl_in;
      logic signed [DW-1:0] x_in, ps_in, sh_in;

      // control enters top-left, runs down column 0, then right along each row
      if (r == 0 && c == 0) begin : g_ctl_src
        assign ctl_in = sa_ctl_t'{en: en_i, sw: switch_i};
      end else if (c == 0) begin : g_ctl_up
        assign ctl_in = ctl_w[r-1][0];
      end else begin : g_ctl_left
        assign ctl_in = ctl_w[r][c-1];
      end

      if (c == 0) begin : g_x_edge
        assign x_in = $signed(x_i[r]);
      end else begin : g_x_left
        assign x_in = x_w[r][c-1];
      end

      if (r == 0) begin : g_top
        assign ps_in = '0;
        assign sh_in = $signed(w_row_i[c]);
        p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
          accept_i |=> sh_w[0][c] == $past($signed(w_row_i[c])));
      end else begin : g_inner
        assign ps_in = ps_w[r-1][c];
        assign sh_in = sh_w[r-1][c];
        p_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
          accept_i |=> sh_w[r][c] == $past(sh_w[r-1][c]));
      end

      sa_pe #(.DW(DW), .FRAC(FRAC)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctl_i  (ctl_in),
        .acc_i  (accept_i),
        .x_i    (x_in),
        .psum_i (ps_in),
        .sh_i   (sh_in),
        .ctl_o  (ctl_w[r][c]),
        .x_o    (x_w[r][c]),
        .psum_o (ps_w[r][c]),
        .sh_o   (sh_w[r][c])
      );
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign y_o[c] = ps_w[N-1][c];
  end
endmodule

// File: tb/sys_array_db_tb.sv
module sys_array_db_tb;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0, sw = 1'b0, acc = 1'b0;
  logic [3:0][15:0] xd = '0, wd = '0;
  logic [1:0][15:0] y2;
  logic [3:0][15:0] y4;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] st;
  int xm [10][4];
  int w1 [4][4];
  int w2 [4][4];

  // columns: size, seed, value range, switch cycle
  localparam int NC = 6;
  localparam int C_N    [NC] = '{2, 2, 4, 4, 2, 4};
  localparam int C_SEED [NC] = '{1, 7, 3, 11, 5, 9};
  localparam int C_RNG  [NC] = '{512, 1024, 768, 256, 32767, 32767};
  localparam int C_K    [NC] = '{3, 5, 5, 9, 3, 6};

  always #10 clk = ~clk; // 50 MHz

  sys_array_db #(.N(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .switch_i(sw), .accept_i(acc),
    .x_i(xd[1:0]), .w_row_i(wd[1:0]), .y_o(y2));

  sys_array_db #(.N(4)) u_dut4 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .switch_i(sw), .accept_i(acc),
    .x_i(xd), .w_row_i(wd), .y_o(y4));

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rmul(int a, int b);
    longint p = longint'(a) * longint'(b);
    p = (p + 128) >>> 8;
    return sat16(p);
  endfunction

  function int rnd_val(int range);
    st = st ^ (st << 13);
    st = st ^ (st >> 17);
    st = st ^ (st << 5);
    return int'(st % (2 * range + 1)) - range;
  endfunction

  function automatic int ref_y(int k, int c, int n, bit use2);
    int a = 0;
    for (int r = 0; r < n; r++) a = sat16(longint'(a) + rmul(xm[k][r], use2 ? w2[r][c] : w1[r][c]));
    return a;
  endfunction

  function automatic int get_y(int n, int c);
    if (n == 2) return int'($signed(y2[c]));
    return int'($signed(y4[c]));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      en = 0; sw = 0; acc = 0;
      for (int r = 0; r < 4; r++) xd[r] = 16'(rnd_val(30000));
    end
  endtask

  task automatic run_case(int n, int seed, int range, int kk);
    int m = 2 * n + 2;
    int tt = m + 2 * n;
    st = 32'(seed) * 32'd2654435761 + 32'd1;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) begin
        w1[r][c] = rnd_val(range);
        w2[r][c] = rnd_val(range);
      end
    for (int k = 0; k < m; k++)
      for (int r = 0; r < n; r++) xm[k][r] = rnd_val(range);
    // preload layer 1, bottom row first (R5)
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc = 1;
      for (int c = 0; c < n; c++) wd[c] = 16'(w1[n-1-i][c]);
    end
    @(negedge clk);
    acc = 0; sw = 1;
    idle(2 * n + 1);
    // stream; layer 2 accepted during the stream, switched at cycle kk
    for (int t = 0; t < tt; t++) begin
      @(negedge clk);
      en  = (t < m);
      sw  = (t == kk);
      acc = (t < n);
      for (int c = 0; c < 4; c++) wd[c] = (t < n && c < n) ? 16'(w2[n-1-t][c]) : 16'(rnd_val(30000));
      for (int r = 0; r < 4; r++) begin
        int k = t - r;
        xd[r] = (r < n && k >= 0 && k < m) ? 16'(xm[k][r]) : 16'(rnd_val(30000));
      end
      @(posedge clk);
      #2;
      // R1 R3: sample k of column c lands at edge k+n-1+c
      for (int c = 0; c < n; c++) begin
        int k = t - (n - 1) - c;
        if (k >= 0 && k < m) begin
          string req;
          if (range > 2000)  req = "R2";
          else if (k >= kk)  req = "R6";
          else if (k < n)    req = "R8";
          else               req = "R3";
          check(req, get_y(n, c), ref_y(k, c, n, k >= kk));
        end
      end
    end
    idle(3);
    @(posedge clk);
    #2;
    for (int c = 0; c < n; c++) check("R4", get_y(n, c), ref_y(m - 1, c, n, (m - 1) >= kk));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    st = 32'd99;
    #35;
    // R7: reset state
    for (int c = 0; c < 2; c++) check("R7", int'($signed(y2[c])), 0);
    for (int c = 0; c < 4; c++) check("R7", int'($signed(y4[c])), 0);
    @(negedge clk);
    rst_n = 1;
    idle(2);
    for (int i = 0; i < NC; i++) run_case(C_N[i], C_SEED[i], C_RNG[i], C_K[i]);
    // R7: asynchronous reset mid-operation clears outputs and weights
    @(negedge clk);
    #3;
    rst_n = 0;
    #1;
    for (int c = 0; c < 4; c++) check("R7", int'($signed(y4[c])), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sw = 1;
    idle(9);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      en = (t < 4);
      for (int r = 0; r < 4; r++) xd[r] = 16'(rnd_val(4000) + 5000);
    end
    @(posedge clk);
    #2;
    for (int c = 0; c < 4; c++) check("R7", int'($signed(y4[c])), 0);
    for (int c = 0; c < 2; c++) check("R7", int'($signed(y2[c])), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule